// File: doc/BRIEF.md
# Address Range Router with Rebase

The block connects one initiator to several targets. Each request carries an address, a write flag and write data. A small table of map entries decides where the request goes. Each entry has an enable, a lower bound (inclusive), an upper bound (exclusive) and a target number. When an entry matches, the router subtracts that entry's lower bound from the address and passes the request to the chosen target. Each target therefore sees addresses that start at zero. The target's answer then goes back to the initiator unchanged. When no entry matches, no target is touched and the initiator gets an error answer one cycle after the request is accepted.

Only one transaction is in flight at a time. The map is loaded through a simple write port. It can be changed while the router is running, but only when no transaction is in flight. After reset, the map sends the first sixteen addresses to target 0 and the next sixteen to target 1. All other entries start disabled.

Top module: `addr_range_router`

## Requirements
- R1: After reset, `ini_req_ready` is 1, `ini_rsp_valid` is 0 and no `tgt_req_valid` bit is set. The held response reads as an error: `ini_rsp_err`=1 and `ini_rsp_rdata`=0.
- R2: Reset map: entry 0 covers 0x00..0x0F and goes to target 0. Entry 1 covers 0x10..0x1F and goes to target 1. All other entries are disabled, so address 0x20 and above miss.
- R3: A range includes its lower bound and excludes its upper bound. With the reset map, 0x0F goes to target 0, 0x10 and 0x1F go to target 1, and 0x20 misses.
- R4: On a hit, `tgt_req_addr` equals the request address minus the lower bound of the matching entry. The write flag and write data are passed through unchanged.
- R5: On a miss, no `tgt_req_valid` bit is raised. `ini_rsp_valid` pulses in the cycle after acceptance, with `ini_rsp_err`=1 and `ini_rsp_rdata`=0.
- R6: On a hit, the target's `tgt_rsp_err` and read data reach `ini_rsp_err` and `ini_rsp_rdata` unchanged. `ini_rsp_valid` pulses in the cycle after the selected target's `tgt_rsp_valid`.
- R7: When more than one entry matches, the entry with the lowest index wins.
- R8: `ini_req_ready` is 0 from the cycle after acceptance through the response cycle. It returns to 1 in the cycle after the response.
- R9: A map write (`map_we`=1, with `map_idx`, `map_en`, `map_lo`, `map_hi`, `map_tgt`) takes effect only while `ini_req_ready` is 1, and it applies from the next request. A write made while a transaction is in flight is dropped. Writing `map_en`=0 disables the entry.
- R10: An entry whose target number is not below N_TGT never matches.
- R11: Exactly one `tgt_req_valid` bit is raised, the one for the selected target. It stays high, with the address and data held, until that target's `tgt_req_ready` is seen. The target answers no earlier than the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ini_req_valid | input | 1 | Initiator request present |
| ini_req_ready | output | 1 | Router idle, request accepted |
| ini_req_write | input | 1 | 1 = write, 0 = read |
| ini_req_addr | input | AW | Request address |
| ini_req_wdata | input | DW | Write data |
| ini_rsp_valid | output | 1 | One-cycle response pulse |
| ini_rsp_err | output | 1 | Response error status |
| ini_rsp_rdata | output | DW | Response read data |
| map_we | input | 1 | Map entry write strobe |
| map_idx | input | EW | Entry index |
| map_en | input | 1 | Entry enable |
| map_lo | input | AW | Inclusive lower bound |
| map_hi | input | AW | Exclusive upper bound |
| map_tgt | input | TW | Target number |
| tgt_req_valid | output | N_TGT | Per-target request strobe |
| tgt_req_ready | input | N_TGT | Per-target acceptance |
| tgt_req_write | output | 1 | Forwarded write flag |
| tgt_req_addr | output | AW | Rebased address |
| tgt_req_wdata | output | DW | Forwarded write data |
| tgt_rsp_valid | input | N_TGT | Per-target response strobe |
| tgt_rsp_err | input | N_TGT | Per-target error status |
| tgt_rsp_rdata | input | N_TGT*DW | Per-target read data, target t at bits t*DW upward |

## Verification
The bench builds the router with N_TGT=3, N_ENT=4, AW=16 and DW=16. Three targets make it possible to program a target number of 3, which fits the two-bit field but is not a real target, so the R10 rejection can be tested. Four entries leave two spare entries beyond the reset map. These are used to program an overlapping range and a range nested inside another, which exercises priority and rebasing. The 16-bit address lets map ranges sit well above the reset ranges, so a rebased address can be clearly told apart from the raw one.

// File: rtl/addr_range_router.sv
module addr_range_router #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int N_TGT = 2,
  parameter int N_ENT = 4,
  localparam int TW = (N_TGT > 1) ? $clog2(N_TGT) : 1,
  localparam int EW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ini_req_valid,
  output logic              ini_req_ready,
  input  logic              ini_req_write,
  input  logic [AW-1:0]     ini_req_addr,
  input  logic [DW-1:0]     ini_req_wdata,
  output logic              ini_rsp_valid,
  output logic              ini_rsp_err,
  output logic [DW-1:0]     ini_rsp_rdata,
  input  logic              map_we,
  input  logic [EW-1:0]     map_idx,
  input  logic              map_en,
  input  logic [AW-1:0]     map_lo,
  input  logic [AW-1:0]     map_hi,
  input  logic [TW-1:0]     map_tgt,
  output logic [N_TGT-1:0]  tgt_req_valid,
  input  logic [N_TGT-1:0]  tgt_req_ready,
  output logic              tgt_req_write,
  output logic [AW-1:0]     tgt_req_addr,
  output logic [DW-1:0]     tgt_req_wdata,
  input  logic [N_TGT-1:0]  tgt_rsp_valid,
  input  logic [N_TGT-1:0]  tgt_rsp_err,
  input  logic [N_TGT*DW-1:0] tgt_rsp_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_FWD, S_WAIT, S_RESP} state_t;

  state_t        st;
  logic [TW-1:0] sel_q;
  logic [AW-1:0] addr_q;
  logic          wr_q;
  logic [DW-1:0] wdata_q;
  logic          rsp_err_q;
  logic [DW-1:0] rsp_data_q;

  logic          ent_en  [N_ENT];
  logic [AW-1:0] ent_lo  [N_ENT];
  logic [AW-1:0] ent_hi  [N_ENT];
  logic [TW-1:0] ent_tgt [N_ENT];

  logic          hit;
  logic [AW-1:0] hit_lo;
  logic [TW-1:0] hit_tgt;
  logic          sel_rsp_valid;
  logic          sel_rsp_err;
  logic [DW-1:0] sel_rsp_rdata;

  wire accept = ini_req_valid && ini_req_ready;

  // lowest index wins: scan from the top so the last match kept is the lowest
  always_comb begin
    hit = 1'b0;
    hit_lo = '0;
    hit_tgt = '0;
    for (int e = N_ENT - 1; e >= 0; e--) begin
      if (ent_en[e] && (int'(ent_tgt[e]) < N_TGT) &&
          (ini_req_addr >= ent_lo[e]) && (ini_req_addr < ent_hi[e])) begin
        hit = 1'b1;
        hit_lo = ent_lo[e];
        hit_tgt = ent_tgt[e];
      end
    end
  end

  always_comb begin
    sel_rsp_valid = 1'b0;
    sel_rsp_err = 1'b1;
    sel_rsp_rdata = '0;
    for (int t = 0; t < N_TGT; t++) begin
      if (sel_q == TW'(t)) begin
        sel_rsp_valid = tgt_rsp_valid[t];
        sel_rsp_err = tgt_rsp_err[t];
        sel_rsp_rdata = tgt_rsp_rdata[t*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < N_ENT; e++) begin
        ent_en[e]  <= (e < 2) && (e < N_TGT);
        ent_lo[e]  <= (e < 2) ? AW'(e * 16) : '0;
        ent_hi[e]  <= (e < 2) ? AW'((e + 1) * 16) : '0;
        ent_tgt[e] <= (e < 2) ? TW'(e) : '0;
      end
    end else if (map_we && st == S_IDLE) begin
      for (int e = 0; e < N_ENT; e++) begin
        if (map_idx == EW'(e)) begin
          ent_en[e]  <= map_en;
          ent_lo[e]  <= map_lo;
          ent_hi[e]  <= map_hi;
          ent_tgt[e] <= map_tgt;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sel_q <= '0;
      addr_q <= '0;
      wr_q <= 1'b0;
      wdata_q <= '0;
      rsp_err_q <= 1'b1;
      rsp_data_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (ini_req_valid) begin
          if (hit) begin
            sel_q <= hit_tgt;
            addr_q <= ini_req_addr - hit_lo;
            wr_q <= ini_req_write;
            wdata_q <= ini_req_wdata;
            st <= S_FWD;
          end else begin
            rsp_err_q <= 1'b1;
            rsp_data_q <= '0;
            st <= S_RESP;
          end
        end
        S_FWD: if (|(tgt_req_valid & tgt_req_ready)) st <= S_WAIT;
        S_WAIT: if (sel_rsp_valid) begin
          rsp_err_q <= sel_rsp_err;
          rsp_data_q <= sel_rsp_rdata;
          st <= S_RESP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ini_req_ready = (st == S_IDLE);
  assign ini_rsp_valid = (st == S_RESP);
  assign ini_rsp_err   = rsp_err_q;
  assign ini_rsp_rdata = rsp_data_q;
  assign tgt_req_write = wr_q;
  assign tgt_req_addr  = addr_q;
  assign tgt_req_wdata = wdata_q;

  for (genvar g = 0; g < N_TGT; g++) begin : g_req
    assign tgt_req_valid[g] = (st == S_FWD) && (sel_q == TW'(g));
  end

  assert_one_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_req_valid));

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|tgt_req_valid) && !(|(tgt_req_valid & tgt_req_ready)) |=>
      (tgt_req_valid == $past(tgt_req_valid)) && $stable(tgt_req_addr) && $stable(tgt_req_wdata));

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ini_req_ready);

  assert_miss_answer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !hit |=> ini_rsp_valid && ini_rsp_err && (ini_rsp_rdata == '0) && (tgt_req_valid == '0));

  assert_rebase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && hit |=> tgt_req_addr == AW'($past(ini_req_addr) - $past(hit_lo)));

  assert_rsp_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) && sel_rsp_valid |=>
      ini_rsp_valid && (ini_rsp_err == $past(sel_rsp_err)) && (ini_rsp_rdata == $past(sel_rsp_rdata)));

endmodule

// File: tb/addr_range_router_tb.sv
module addr_range_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int NT = 3;
  localparam int NE = 4;
  localparam int TW = 2;
  localparam int EW = 2;

  logic clk = 0;
  logic rst_n = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic ini_req_valid = 0, ini_req_write = 0;
  logic [AW-1:0] ini_req_addr = '0;
  logic [DW-1:0] ini_req_wdata = '0;
  logic ini_req_ready, ini_rsp_valid, ini_rsp_err;
  logic [DW-1:0] ini_rsp_rdata;
  logic map_we = 0, map_en = 0;
  logic [EW-1:0] map_idx = '0;
  logic [AW-1:0] map_lo = '0, map_hi = '0;
  logic [TW-1:0] map_tgt = '0;
  logic [NT-1:0] tgt_req_valid;
  logic [NT-1:0] tready = '1;
  logic tgt_req_write;
  logic [AW-1:0] tgt_req_addr;
  logic [DW-1:0] tgt_req_wdata;
  logic [NT-1:0] rsp_v, rsp_e;
  logic [NT*DW-1:0] rsp_d;
  logic [NT-1:0] err_force = '0;

  addr_range_router #(.AW(AW), .DW(DW), .N_TGT(NT), .N_ENT(NE)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ini_req_valid(ini_req_valid), .ini_req_ready(ini_req_ready),
    .ini_req_write(ini_req_write), .ini_req_addr(ini_req_addr), .ini_req_wdata(ini_req_wdata),
    .ini_rsp_valid(ini_rsp_valid), .ini_rsp_err(ini_rsp_err), .ini_rsp_rdata(ini_rsp_rdata),
    .map_we(map_we), .map_idx(map_idx), .map_en(map_en), .map_lo(map_lo), .map_hi(map_hi),
    .map_tgt(map_tgt),
    .tgt_req_valid(tgt_req_valid), .tgt_req_ready(tready), .tgt_req_write(tgt_req_write),
    .tgt_req_addr(tgt_req_addr), .tgt_req_wdata(tgt_req_wdata),
    .tgt_rsp_valid(rsp_v), .tgt_rsp_err(rsp_e), .tgt_rsp_rdata(rsp_d)
  );

  // behavioural targets: 16-word stores indexed by address bits [3:0]
  logic [DW-1:0] mem [NT][16];
  int acc_cnt, last_t;
  logic [AW-1:0] last_addr;
  logic last_wr;
  logic [DW-1:0] last_wd;

  always @(posedge clk) begin
    if (!rst_n) begin
      acc_cnt <= 0; last_t <= -1; last_addr <= '0; last_wr <= 0; last_wd <= '0;
      rsp_v <= '0; rsp_e <= '0; rsp_d <= '0;
      for (int t = 0; t < NT; t++) for (int k = 0; k < 16; k++) mem[t][k] <= '0;
    end else begin
      rsp_v <= '0;
      for (int t = 0; t < NT; t++) begin
        if (tgt_req_valid[t] && tready[t]) begin
          rsp_v[t] <= 1'b1;
          rsp_e[t] <= err_force[t];
          rsp_d[t*DW +: DW] <= tgt_req_write ? tgt_req_wdata : mem[t][tgt_req_addr[3:0]];
          if (tgt_req_write) mem[t][tgt_req_addr[3:0]] <= tgt_req_wdata;
          acc_cnt <= acc_cnt + 1;
          last_t <= t; last_addr <= tgt_req_addr; last_wr <= tgt_req_write; last_wd <= tgt_req_wdata;
        end
      end
    end
  end

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [DW-1:0] r_data;
  logic r_err, r_ready_ok;
  int r_lat, acc0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic txn(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd);
    @(negedge clk);
    acc0 = acc_cnt;
    ini_req_valid = 1; ini_req_write = wr; ini_req_addr = a; ini_req_wdata = wd;
    @(negedge clk);
    ini_req_valid = 0;
    r_lat = 0; r_ready_ok = 1;
    while (!ini_rsp_valid && r_lat < 50) begin
      if (ini_req_ready) r_ready_ok = 0;
      @(negedge clk);
      r_lat++;
    end
    if (ini_req_ready) r_ready_ok = 0;
    r_data = ini_rsp_rdata; r_err = ini_rsp_err;
  endtask

  task automatic map_write(input int idx, input logic en, input int lo, input int hi, input int tg);
    @(negedge clk);
    map_we = 1; map_idx = EW'(idx); map_en = en; map_lo = AW'(lo); map_hi = AW'(hi); map_tgt = TW'(tg);
    @(negedge clk);
    map_we = 0;
  endtask

  task automatic hit_check(input string tag, input logic wr, input int a, input int wd,
                           input int exp_t, input int exp_addr, input int exp_rd);
    txn(wr, AW'(a), DW'(wd));
    chk({tag, " target"}, last_t, exp_t);
    chk({tag, " rebased addr"}, last_addr, exp_addr);
    chk({tag, " write flag"}, last_wr, wr);
    if (wr) chk({tag, " wdata"}, last_wd, wd);
    chk({tag, " latency"}, r_lat, 2);
    chk({tag, " err"}, r_err, 0);
    if (!wr) chk({tag, " rdata"}, r_data, exp_rd);
    chk({tag, " one access"}, acc_cnt - acc0, 1);
  endtask

  task automatic miss_check(input string tag, input int a);
    txn(1'b0, AW'(a), '0);
    chk({tag, " miss latency"}, r_lat, 0);
    chk({tag, " miss err"}, r_err, 1);
    chk({tag, " miss rdata"}, r_data, 0);
    chk({tag, " no target access"}, acc_cnt - acc0, 0);
  endtask

  task automatic t_reset;
    chk("R1 ready", ini_req_ready, 1);
    chk("R1 rsp_valid", ini_rsp_valid, 0);
    chk("R1 rsp_err", ini_rsp_err, 1);
    chk("R1 rdata", ini_rsp_rdata, 0);
    chk("R1 tgt_req_valid", tgt_req_valid, 0);
  endtask

  task automatic t_default_map;
    hit_check("R2 wr t0", 1, 'h03, 'hA5A5, 0, 'h03, 0);
    hit_check("R2 wr t1", 1, 'h15, 'h1234, 1, 'h05, 0);
    hit_check("R2 rd t0", 0, 'h03, 0, 0, 'h03, 'hA5A5);
    hit_check("R6 rd t1", 0, 'h15, 0, 1, 'h05, 'h1234);
    chk("R8 ready low in flight", r_ready_ok, 1);
    @(negedge clk);
    chk("R8 ready back after response", ini_req_ready, 1);
  endtask

  task automatic t_bounds;
    hit_check("R3 0x0F", 1, 'h0F, 'h0F0F, 0, 'h0F, 0);
    hit_check("R3 0x10", 1, 'h10, 'h1010, 1, 'h00, 0);
    hit_check("R4 0x1F", 1, 'h1F, 'h1F1F, 1, 'h0F, 0);
    miss_check("R3 0x20", 'h20);
  endtask

  task automatic t_miss;
    miss_check("R5 far", 'hF000);
    chk("R8 ready low in miss response", r_ready_ok, 1);
    miss_check("R2 entry2 disabled", 'h25);
  endtask

  task automatic t_err_pass;
    err_force[1] = 1;
    txn(1'b0, AW'('h10), '0);
    chk("R6 err passed", r_err, 1);
    chk("R6 rdata passed with err", r_data, 'h1010);
    err_force[1] = 0;
  endtask

  task automatic t_busy_map;
    tready[0] = 0;
    @(negedge clk);
    acc0 = acc_cnt;
    ini_req_valid = 1; ini_req_write = 1; ini_req_addr = AW'('h07); ini_req_wdata = 'h7777;
    @(negedge clk);
    ini_req_valid = 0;
    map_we = 1; map_idx = 0; map_en = 1; map_lo = 'h40; map_hi = 'h50; map_tgt = 1;
    for (int k = 0; k < 3; k++) begin
      chk("R11 held valid", tgt_req_valid, 3'b001);
      chk("R11 held addr", tgt_req_addr, 'h07);
      chk("R8 ready low while stalled", ini_req_ready, 0);
      @(negedge clk);
      map_we = 0;
    end
    tready[0] = 1;
    r_lat = 0;
    while (!ini_rsp_valid && r_lat < 50) begin @(negedge clk); r_lat++; end
    chk("R11 response after stall", ini_rsp_err, 0);
    hit_check("R9 busy write dropped", 0, 'h07, 0, 0, 'h07, 'h7777);
    miss_check("R9 busy range absent", 'h45);
  endtask

  task automatic t_new_entry;
    map_write(2, 1, 'h100, 'h140, 2);
    hit_check("R9 new entry wr", 1, 'h123, 'hBEEF, 2, 'h23, 0);
    hit_check("R4 new entry rd", 0, 'h123, 0, 2, 'h23, 'hBEEF);
  endtask

  task automatic t_overlap;
    map_write(3, 1, 'h000, 'h200, 2);
    hit_check("R7 entry0 beats entry3", 0, 'h05, 0, 0, 'h05, 0);
    hit_check("R7 entry2 beats entry3", 0, 'h120, 0, 2, 'h20, 0);
    hit_check("R7 only entry3", 0, 'h180, 0, 2, 'h180, 0);
  endtask

  task automatic t_bad_tgt;
    map_write(3, 1, 'h300, 'h310, 3);
    miss_check("R10 target 3", 'h305);
  endtask

  task automatic t_disable;
    map_write(1, 0, 'h10, 'h20, 1);
    miss_check("R9 disabled entry1", 'h15);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_default_map();
    t_bounds();
    t_miss();
    t_err_pass();
    t_busy_map();
    t_new_entry();
    t_overlap();
    t_bad_tgt();
    t_disable();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule